// File: doc/BRIEF.md
# Prioritized Register Back-Door Arbiter

This block gives several embedded microcores and one external host port shared access to a single configuration register bank. The bank has 8-bit addresses and 16-bit words. The host port (for example the parallel side of a serial slave front end) always has precedence. The microcores share whatever bank cycles the host leaves free, and they take turns in round-robin order.

Each microcore owns a small mailbox made of an address register and a data register. To make an access, a core loads the target address into the address register. For a write it also loads the value into the data register. It then pulses a read or a write request for one cycle. The block raises the core's busy flag, performs the bank access and finishes the operation. For a read, the result is placed in the mailbox data register. While a core has no access in flight, its two mailbox registers are plain spare storage and have no side effects.

The host request channel uses valid/ready. `host_ready` is held high because the host is never back-pressured: a host request with `host_valid` high is issued to the bank in that same cycle. Read data returns on `host_rvalid`/`host_rdata` one cycle later. That return channel has no ready signal, so the host must accept the data when it arrives.

Top module: `regbank_backdoor_arb`

## Requirements
- R1: While `host_valid` is high, the bank port carries the host request in that same cycle: `bank_en`=1 and `bank_addr`/`bank_we`/`bank_wdata` equal the host inputs, and no microcore is served in that cycle. `host_ready` is always 1. A host read in cycle c returns `host_rvalid`=1 with the word in cycle c+1.
- R2: While a core is not busy, a write strobe on its address or data mailbox updates `core_addr_q`/`core_data_q` on the next cycle. Such a write causes no bank access.
- R3: A read request in cycle c from a core that is not busy, with the host idle, issues the bank read in cycle c+1. The core's busy flag is 1 in cycles c+1 and c+2 and 0 in cycle c+3. From cycle c+3 `core_data_q` holds the bank word.
- R4: A write request from a core issues a bank write in the next free cycle, using the mailbox address and data. The mailbox data register keeps its value.
- R5: A mailbox address or data write made while the core is busy is ignored. The core's `core_proto_err` bit is 1 for exactly the following cycle.
- R6: A read or write request from a core that is already busy is ignored and causes no extra bank access.
- R7: A core request that loses to the host stays pending. It is served in the first cycle in which `host_valid` is low.
- R8: Pending core requests are granted one per cycle in round-robin order. The search starts at the core after the one last granted.
- R9: When a core raises its read and write requests in the same cycle, the operation is a write.
- R10: After reset, all mailbox registers read 0, all busy and error flags are 0, `host_rvalid` is 0, and the round-robin search starts at core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted (always 1) |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 16 | Host write word |
| host_rvalid | output | 1 | Host read word valid (one cycle after the request) |
| host_rdata | output | 16 | Host read word |
| core_addr_we | input | N | Per-core mailbox address write strobe |
| core_addr_wd | input | 8*N | Per-core mailbox address write value |
| core_data_we | input | N | Per-core mailbox data write strobe |
| core_data_wd | input | 16*N | Per-core mailbox data write value |
| core_rd_req | input | N | Per-core read request pulse |
| core_wr_req | input | N | Per-core write request pulse |
| core_addr_q | output | 8*N | Per-core mailbox address contents |
| core_data_q | output | 16*N | Per-core mailbox data contents |
| core_busy | output | N | Per-core access in flight |
| core_proto_err | output | N | Per-core pulse: mailbox written while busy |
| bank_en | output | 1 | Bank access strobe |
| bank_we | output | 1 | Bank access is a write |
| bank_addr | output | 8 | Bank address |
| bank_wdata | output | 16 | Bank write word |
| bank_rdata | input | 16 | Bank read word, valid one cycle after a read strobe |

## Verification
The arbiter is driven with several input patterns:
- A single core with the host idle, which pins down the exact cycles of the grant, the busy flag and the returned read data.
- Host traffic held across a core request, which separates a deferred request from a dropped one.
- All three cores requesting in the same cycle, once right after reset and once after a lone grant. This exposes fixed-priority or wrongly rotated arbitration in the order of the logged bank addresses.
- Mailbox writes and repeated requests made during busy, which show whether protected state leaks through.
- Read and write requests raised together, which show which operation wins.
- Random single-core reads and writes under random host read bursts, checked against a shadow of the bank contents.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [1:0] {
    MB_IDLE = 2'd0,
    MB_PEND = 2'd1,
    MB_WAIT = 2'd2
  } mb_state_t;
endpackage

// File: rtl/bd_mailbox.sv
module bd_mailbox
  import bd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wd,
  input  logic          data_we,
  input  logic [DW-1:0] data_wd,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          grant,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          busy,
  output logic          pend,
  output logic          op_wr,
  output logic          proto_err
);
  mb_state_t state_q;

  assign busy = (state_q != MB_IDLE);
  assign pend = (state_q == MB_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= MB_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      op_wr     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= busy && (addr_we || data_we);
      case (state_q)
        MB_IDLE: begin
          if (addr_we) addr_q <= addr_wd;
          if (data_we) data_q <= data_wd;
          if (rd_req || wr_req) begin
            state_q <= MB_PEND;
            op_wr   <= wr_req;
          end
        end
        MB_PEND: if (grant) state_q <= MB_WAIT;
        MB_WAIT: begin
          state_q <= MB_IDLE;
          if (!op_wr) data_q <= rdata;
        end
        default: state_q <= MB_IDLE;
      endcase
    end
  end

  AST_MB_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q)); // R5
  AST_MB_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(busy)); // R5
  AST_MB_DONE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && pend) |=> busy ##1 !busy); // R3
endmodule

// File: rtl/bd_rr_arbiter.sv
module bd_rr_arbiter #(
  parameter int N = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          block,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_any,
  output logic [PW-1:0] gnt_idx
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] idx;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    idx     = '0;
    for (int k = 0; k < N; k++) begin
      idx = PW'((int'(ptr_q) + k) % N);
      if (!block && !found && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = idx;
        found    = 1'b1;
      end
    end
    gnt_any = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_any) begin
      ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_ARB_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req) && !block) |-> (|gnt)); // R7
endmodule

// File: rtl/regbank_backdoor_arb.sv
module regbank_backdoor_arb #(
  parameter int N  = 3,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_valid,
  output logic            host_ready,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic            host_rvalid,
  output logic [DW-1:0]   host_rdata,
  input  logic [N-1:0]    core_addr_we,
  input  logic [N*AW-1:0] core_addr_wd,
  input  logic [N-1:0]    core_data_we,
  input  logic [N*DW-1:0] core_data_wd,
  input  logic [N-1:0]    core_rd_req,
  input  logic [N-1:0]    core_wr_req,
  output logic [N*AW-1:0] core_addr_q,
  output logic [N*DW-1:0] core_data_q,
  output logic [N-1:0]    core_busy,
  output logic [N-1:0]    core_proto_err,
  output logic            bank_en,
  output logic            bank_we,
  output logic [AW-1:0]   bank_addr,
  output logic [DW-1:0]   bank_wdata,
  input  logic [DW-1:0]   bank_rdata
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [AW-1:0] mb_addr [N];
  logic [DW-1:0] mb_data [N];
  logic [N-1:0]  mb_pend;
  logic [N-1:0]  mb_wr;
  logic [N-1:0]  gnt;
  logic          gnt_any;
  logic [PW-1:0] gnt_idx;
  logic          rvalid_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mb
      bd_mailbox #(.AW(AW), .DW(DW)) u_mb (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (core_addr_we[g]),
        .addr_wd   (core_addr_wd[g*AW +: AW]),
        .data_we   (core_data_we[g]),
        .data_wd   (core_data_wd[g*DW +: DW]),
        .rd_req    (core_rd_req[g]),
        .wr_req    (core_wr_req[g]),
        .grant     (gnt[g]),
        .rdata     (bank_rdata),
        .addr_q    (mb_addr[g]),
        .data_q    (mb_data[g]),
        .busy      (core_busy[g]),
        .pend      (mb_pend[g]),
        .op_wr     (mb_wr[g]),
        .proto_err (core_proto_err[g])
      );
      assign core_addr_q[g*AW +: AW] = mb_addr[g];
      assign core_data_q[g*DW +: DW] = mb_data[g];
    end
  endgenerate

  bd_rr_arbiter #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .block   (host_valid),
    .req     (mb_pend),
    .gnt     (gnt),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  always_comb begin
    bank_en = host_valid || gnt_any;
    if (host_valid) begin
      bank_we    = host_we;
      bank_addr  = host_addr;
      bank_wdata = host_wdata;
    end else begin
      bank_we    = mb_wr[gnt_idx];
      bank_addr  = mb_addr[gnt_idx];
      bank_wdata = mb_data[gnt_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= host_valid && !host_we;
  end

  assign host_ready  = 1'b1;
  assign host_rvalid = rvalid_q;
  assign host_rdata  = bank_rdata;

  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> (bank_en && bank_addr == host_addr && bank_we == host_we)); // R1
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> ((gnt & mb_pend & core_busy) == gnt)); // R8
endmodule

// File: tb/sim_regbank_backdoor_arb.sv
module sim_regbank_backdoor_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         host_valid = 0, host_we = 0;
  logic [7:0]   host_addr = 0;
  logic [15:0]  host_wdata = 0;
  logic         host_ready, host_rvalid;
  logic [15:0]  host_rdata;
  logic [N-1:0] addr_we = 0, data_we = 0, rd_req = 0, wr_req = 0;
  logic [N*8-1:0]  addr_wd = 0;
  logic [N*16-1:0] data_wd = 0;
  logic [N*8-1:0]  addr_q;
  logic [N*16-1:0] data_q;
  logic [N-1:0] busy, perr;
  logic         bank_en, bank_we;
  logic [7:0]   bank_addr;
  logic [15:0]  bank_wdata;
  logic [15:0]  bank_rdata = 0;

  regbank_backdoor_arb #(.N(N), .AW(8), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .core_addr_we(addr_we), .core_addr_wd(addr_wd),
    .core_data_we(data_we), .core_data_wd(data_wd),
    .core_rd_req(rd_req), .core_wr_req(wr_req),
    .core_addr_q(addr_q), .core_data_q(data_q),
    .core_busy(busy), .core_proto_err(perr),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  logic [15:0] bmem [256];
  logic [15:0] shadow [256];
  int cyc = 0, acc_cnt = 0, last_cyc = -1, nlog = 0;
  logic [7:0] last_addr = 0;
  logic last_we = 0;
  logic [7:0] log_addr [8];

  always @(posedge clk) begin
    if (bank_en) begin
      if (bank_we) bmem[bank_addr] <= bank_wdata;
      else         bank_rdata <= bmem[bank_addr];
      acc_cnt++;
      last_cyc  = cyc;
      last_addr = bank_addr;
      last_we   = bank_we;
      if (nlog < 8) log_addr[nlog] = bank_addr;
      nlog++;
    end
    cyc++;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fill_word(input int a);
    return 16'(a * 37) ^ 16'h5a5a;
  endfunction

  task automatic mb_load(input int c, input logic [7:0] a, input logic [15:0] d);
    addr_we[c] = 1; addr_wd[c*8 +: 8] = a;
    data_we[c] = 1; data_wd[c*16 +: 16] = d;
    @(negedge clk);
    addr_we[c] = 0; data_we[c] = 0;
  endtask

  task automatic wait_idle(input int c);
    for (int k = 0; k < 50 && busy[c]; k++) @(negedge clk);
  endtask

  task automatic core_op(input int c, input logic wr);
    if (wr) wr_req[c] = 1; else rd_req[c] = 1;
    @(negedge clk);
    wr_req[c] = 0; rd_req[c] = 0;
    @(negedge clk);
    wait_idle(c);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
    host_valid = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 0; host_we = 0;
    shadow[a] = d;
  endtask

  task automatic host_rd_check(input string req, input logic [7:0] a);
    host_valid = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_valid = 0;
    chk({req, " host_rvalid"}, 32'(host_rvalid), 32'd1);
    chk({req, " host_rdata"}, 32'(host_rdata), 32'(shadow[a]));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0, n0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 perr", 32'(perr), 0);
    chk("R10 addr_q", 32'(addr_q), 0);
    chk("R10 data_q", 32'(data_q), 0);
    chk("R10 host_rvalid", 32'(host_rvalid), 0);
    chk("R1 host_ready", 32'(host_ready), 1);

    // R2 spare storage
    n0 = acc_cnt;
    mb_load(0, 8'hAB, 16'h1234);
    chk("R2 addr_q", 32'(addr_q[7:0]), 32'hAB);
    chk("R2 data_q", 32'(data_q[15:0]), 32'h1234);
    data_we[0] = 1; data_wd[15:0] = 16'h4321;
    @(negedge clk); data_we[0] = 0;
    chk("R2 data_q rewrite", 32'(data_q[15:0]), 32'h4321);
    chk("R2 no bank access", 32'(acc_cnt - n0), 0);

    for (int a = 0; a < 256; a++) host_wr(8'(a), fill_word(a));
    host_rd_check("R1", 8'h05);
    host_rd_check("R1", 8'hF0);

    // R3 uncontended read timing
    mb_load(0, 8'h10, 16'h0);
    c0 = cyc;
    rd_req[0] = 1;
    @(negedge clk); rd_req[0] = 0;
    chk("R3 busy c+1", 32'(busy[0]), 1);
    @(negedge clk);
    chk("R3 busy c+2", 32'(busy[0]), 1);
    chk("R3 access cycle", 32'(last_cyc), 32'(c0 + 1));
    chk("R3 access addr", 32'(last_addr), 32'h10);
    @(negedge clk);
    chk("R3 busy c+3", 32'(busy[0]), 0);
    chk("R3 read data", 32'(data_q[15:0]), 32'(shadow[8'h10]));

    // R4 write
    mb_load(0, 8'h20, 16'hBEEF);
    core_op(0, 1'b1);
    shadow[8'h20] = 16'hBEEF;
    chk("R4 last_we", 32'(last_we), 1);
    chk("R4 data kept", 32'(data_q[15:0]), 32'hBEEF);
    host_rd_check("R4", 8'h20);

    // R5 mailbox write while busy
    mb_load(0, 8'h30, 16'h1111);
    wr_req[0] = 1;
    @(negedge clk); wr_req[0] = 0;
    addr_we[0] = 1; addr_wd[7:0] = 8'h31;
    data_we[0] = 1; data_wd[15:0] = 16'h2222;
    @(negedge clk); addr_we[0] = 0; data_we[0] = 0;
    chk("R5 proto_err pulse", 32'(perr[0]), 1);
    @(negedge clk);
    chk("R5 proto_err cleared", 32'(perr[0]), 0);
    chk("R5 addr kept", 32'(addr_q[7:0]), 32'h30);
    chk("R5 data kept", 32'(data_q[15:0]), 32'h1111);
    shadow[8'h30] = 16'h1111;
    host_rd_check("R5", 8'h30);
    host_rd_check("R5", 8'h31);

    // R6 request while busy ignored
    mb_load(0, 8'h40, 16'h0);
    n0 = acc_cnt;
    rd_req[0] = 1;
    @(negedge clk);
    @(negedge clk); rd_req[0] = 0;
    wait_idle(0);
    repeat (3) @(negedge clk);
    chk("R6 one access", 32'(acc_cnt - n0), 1);
    chk("R6 read data", 32'(data_q[15:0]), 32'(shadow[8'h40]));

    // R7 host contention
    mb_load(1, 8'h50, 16'h0);
    c0 = cyc;
    rd_req[1] = 1;
    host_valid = 1; host_we = 0; host_addr = 8'h60;
    @(negedge clk); rd_req[1] = 0;
    chk("R7 pending busy", 32'(busy[1]), 1);
    chk("R1 rvalid under contention", 32'(host_rvalid), 1);
    chk("R1 rdata under contention", 32'(host_rdata), 32'(shadow[8'h60]));
    @(negedge clk);
    @(negedge clk); host_valid = 0;
    @(negedge clk);
    chk("R7 served cycle", 32'(last_cyc), 32'(c0 + 3));
    chk("R7 served addr", 32'(last_addr), 32'h50);
    wait_idle(1);
    chk("R7 read data", 32'(data_q[31:16]), 32'(shadow[8'h50]));

    // R9 read and write together
    mb_load(2, 8'h70, 16'hA5A5);
    rd_req[2] = 1; wr_req[2] = 1;
    @(negedge clk); rd_req[2] = 0; wr_req[2] = 0;
    @(negedge clk); wait_idle(2);
    shadow[8'h70] = 16'hA5A5;
    chk("R9 was write", 32'(last_we), 1);
    chk("R9 data kept", 32'(data_q[47:32]), 32'hA5A5);
    host_rd_check("R9", 8'h70);

    // R8 round robin from reset
    do_reset();
    chk("R10 mailbox cleared", 32'(data_q), 0);
    addr_we = 3'b111; addr_wd = {8'h83, 8'h82, 8'h81};
    @(negedge clk); addr_we = 0;
    nlog = 0;
    rd_req = 3'b111;
    @(negedge clk); rd_req = 0;
    for (int k = 0; k < 10 && busy != 0; k++) @(negedge clk);
    chk("R8 first", 32'(log_addr[0]), 32'h81);
    chk("R8 second", 32'(log_addr[1]), 32'h82);
    chk("R8 third", 32'(log_addr[2]), 32'h83);
    chk("R8 data core2", 32'(data_q[47:32]), 32'(shadow[8'h83]));
    core_op(1, 1'b0);
    nlog = 0;
    rd_req = 3'b111;
    @(negedge clk); rd_req = 0;
    for (int k = 0; k < 10 && busy != 0; k++) @(negedge clk);
    chk("R8 rotated first", 32'(log_addr[0]), 32'h83);
    chk("R8 rotated second", 32'(log_addr[1]), 32'h81);
    chk("R8 rotated third", 32'(log_addr[2]), 32'h82);

    // random mix: R3 R4 R7
    for (int it = 0; it < 40; it++) begin
      int c, hb;
      logic wr;
      logic [7:0] a;
      logic [15:0] d;
      c  = int'($urandom % 3);
      wr = 1'($urandom);
      a  = 8'($urandom);
      d  = 16'($urandom);
      hb = int'($urandom % 4);
      mb_load(c, a, d);
      if (wr) wr_req[c] = 1; else rd_req[c] = 1;
      if (hb > 0) begin host_valid = 1; host_we = 0; host_addr = 8'($urandom); end
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        wr_req[c] = 0; rd_req[c] = 0;
        if (k + 1 >= hb) host_valid = 0;
      end
      wait_idle(c);
      if (wr) begin
        shadow[a] = d;
        host_rd_check("R4 random", a);
      end else begin
        chk("R3 random read", 32'(data_q[c*16 +: 16]), 32'(shadow[a]));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule